// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This block sequences instruction fetch for a small Harvard CPU. It keeps a 13-bit program counter and an upper-bit latch register that software writes. It also keeps an eight-level hardware return stack. The decoder drives one strobe per request, together with the operand it needs: an 8-bit data byte or an 11-bit branch immediate. The block presents the next fetch address on `fetch_addr` and the low byte of the counter on `pcl_rd`. The upper counter bits are not visible anywhere else.

The counter can advance by one. It can take a computed value, where the data byte is written into the low byte and the upper five bits come from the latch. A jump or a subroutine call replaces the low eleven bits with the immediate and takes only the top two page bits from the latch. A subroutine return pops the full address from the stack. Interrupt entry saves the return address and vectors to word 4. The stack is a ring with no overflow detection: pushes past the eighth overwrite the oldest entries, and pops past the bottom simply reach older slots.

Each request is decoded into a named operation: HOLD, INC, PCL_WRITE, GOTO, CALL, RET or IRQ. The counter register moves on the next clock edge. Reset is asynchronous and active low, and it starts fetch at word 0. The parameter `MEM_WORDS` sets the implemented program size, and every computed address wraps within it.

Top module: `pcseq_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `fetch_addr` and `pcl_rd` read 0. The upper latch and the stack pointer also start at 0.
- R2: With only `op_inc` asserted, `fetch_addr` becomes (previous + 1) modulo `MEM_WORDS` on the next edge.
- R3: With `op_pcl_wr` the highest active strobe, the counter becomes {latch[4:0], wr_data[7:0]}. The latch value used is the one held before this edge. `pcl_rd` always equals `fetch_addr[7:0]`.
- R4: With `op_goto` the highest active strobe, the counter becomes {latch[4:3], imm[10:0]}.
- R5: `op_call` loads the same target as R4 and pushes (counter + 1) modulo `MEM_WORDS` onto the stack.
- R6: `op_ret` pops the most recently pushed 13-bit value into the counter and moves the stack pointer down by one.
- R7: `op_irq` loads address 4 and pushes (counter + 1) modulo `MEM_WORDS`.
- R8: The stack has 8 slots and a 3-bit pointer that wraps modulo 8 on push and pop. After ten calls, ten returns give the return addresses of calls 10 down to 3, followed by those of calls 10 and 9.
- R9: A write of `wr_data[4:0]` to the latch via `op_latch_wr`, with no other strobe, leaves the counter unchanged. The latch keeps its value across all branches until it is written again.
- R10: With no strobe asserted, the counter holds its value.
- R11: Every computed address is reduced modulo `MEM_WORDS`. With 4096 words, latch bit 4 and the top bit of any sum are dropped.
- R12: When several strobes are active, the priority is irq, then ret, then call, then goto, then pcl write, then inc. A latch write happens independently of the other strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_inc | input | 1 | Advance counter by one |
| op_pcl_wr | input | 1 | Write low byte, upper bits from latch |
| op_goto | input | 1 | Jump to immediate within latch page |
| op_call | input | 1 | Jump as goto and push return address |
| op_ret | input | 1 | Pop return address into counter |
| op_irq | input | 1 | Interrupt entry to word 4, push return address |
| op_latch_wr | input | 1 | Load upper-bit latch from wr_data[4:0] |
| wr_data | input | 8 | Data byte for low-byte and latch writes |
| imm | input | 11 | Branch immediate |
| fetch_addr | output | 13 | Current fetch address |
| pcl_rd | output | 8 | Readable low byte of the counter |

## Verification
The bench builds the block with 4096 words. For the low-byte write, it sweeps all 32 latch values against bytes at the edges and in the middle of the range. This separates each latch bit's effect from the others and shows that bit 4 is dropped. For jumps, it sweeps the four page selections against immediates at the low end, the high end and with alternating bits. This separates page bits taken from the latch from bits taken from the immediate. Nested calls ten deep, plus interrupt entry, expose ring wrap and the order of return addresses. Combined strobes confirm each pairwise priority, and increments across the top of memory confirm wrap.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_INC,
        OP_PCL,
        OP_GOTO,
        OP_CALL,
        OP_RET,
        OP_IRQ
    } op_e;
endpackage

// File: rtl/pcseq_latch.sv
module pcseq_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     pop,
    input  logic [W-1:0]             push_val,
    output logic [W-1:0]             top_val,
    output logic [$clog2(DEPTH)-1:0] sp_o
);
    localparam int SP_W = $clog2(DEPTH);
    localparam logic [SP_W-1:0] ONE = SP_W'(1);

    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_dec;
    logic [W-1:0]    ent [DEPTH];

    assign sp_dec = sp_q - ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sp_q <= '0;
        else if (push) sp_q <= sp_q + ONE;
        else if (pop)  sp_q <= sp_dec;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             ent[g] <= '0;
            else if (push && sp_q == SP_W'(g))      ent[g] <= push_val;
        end
    end

    assign top_val = ent[sp_dec];
    assign sp_o    = sp_q;
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int PC_W      = 13,
    parameter int IMM_W     = 11,
    parameter int MEM_WORDS = 8192
) (
    input  op_e                 op,
    input  logic [PC_W-1:0]     pc,
    input  logic [PC_W-9:0]     latch,
    input  logic [7:0]          data,
    input  logic [IMM_W-1:0]    imm,
    input  logic [PC_W-1:0]     pop_val,
    output logic [PC_W-1:0]     ret_addr,
    output logic [PC_W-1:0]     nxt
);
    localparam int HI_W   = PC_W - 8;
    localparam int PAGE_W = PC_W - IMM_W;
    localparam logic [PC_W-1:0] MASK = PC_W'(MEM_WORDS - 1);
    localparam logic [PC_W-1:0] VEC  = PC_W'(4);

    logic [PC_W-1:0] raw;

    assign ret_addr = (pc + PC_W'(1)) & MASK;

    always_comb begin
        unique case (op)
            OP_INC:           raw = ret_addr;
            OP_PCL:           raw = {latch, data};
            OP_GOTO, OP_CALL: raw = {latch[HI_W-1 -: PAGE_W], imm};
            OP_RET:           raw = pop_val;
            OP_IRQ:           raw = VEC;
            default:          raw = pc;
        endcase
        nxt = raw & MASK;
    end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int PC_W      = 13,
    parameter int IMM_W     = 11,
    parameter int DEPTH     = 8,
    parameter int MEM_WORDS = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_inc,
    input  logic             op_pcl_wr,
    input  logic             op_goto,
    input  logic             op_call,
    input  logic             op_ret,
    input  logic             op_irq,
    input  logic             op_latch_wr,
    input  logic [7:0]       wr_data,
    input  logic [IMM_W-1:0] imm,
    output logic [PC_W-1:0]  fetch_addr,
    output logic [7:0]       pcl_rd
);
    localparam int HI_W = PC_W - 8;
    localparam int SP_W = $clog2(DEPTH);

    op_e             op;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_nxt;
    logic [PC_W-1:0] ret_addr;
    logic [PC_W-1:0] pop_val;
    logic [HI_W-1:0] latch_q;
    logic [SP_W-1:0] sp_q;
    logic            do_push;
    logic            do_pop;

    always_comb begin
        if      (op_irq)    op = OP_IRQ;
        else if (op_ret)    op = OP_RET;
        else if (op_call)   op = OP_CALL;
        else if (op_goto)   op = OP_GOTO;
        else if (op_pcl_wr) op = OP_PCL;
        else if (op_inc)    op = OP_INC;
        else                op = OP_HOLD;
    end

    assign do_push = (op == OP_CALL) || (op == OP_IRQ);
    assign do_pop  = (op == OP_RET);

    pcseq_latch #(.W(HI_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (op_latch_wr),
        .d     (wr_data[HI_W-1:0]),
        .q     (latch_q)
    );

    pcseq_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .pop      (do_pop),
        .push_val (ret_addr),
        .top_val  (pop_val),
        .sp_o     (sp_q)
    );

    pcseq_target #(.PC_W(PC_W), .IMM_W(IMM_W), .MEM_WORDS(MEM_WORDS)) u_tgt (
        .op       (op),
        .pc       (pc_q),
        .latch    (latch_q),
        .data     (wr_data),
        .imm      (imm),
        .pop_val  (pop_val),
        .ret_addr (ret_addr),
        .nxt      (pc_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    assign fetch_addr = pc_q;
    assign pcl_rd     = pc_q[7:0];
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
    parameter int PC_W      = 13,
    parameter int IMM_W     = 11,
    parameter int DEPTH     = 8,
    parameter int MEM_WORDS = 8192
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     op_inc,
    input logic                     op_pcl_wr,
    input logic                     op_goto,
    input logic                     op_call,
    input logic                     op_ret,
    input logic                     op_irq,
    input logic                     op_latch_wr,
    input logic [7:0]               wr_data,
    input logic [IMM_W-1:0]         imm,
    input logic [PC_W-1:0]          fetch_addr,
    input logic [PC_W-9:0]          latch_q,
    input logic [$clog2(DEPTH)-1:0] sp_q
);
    localparam int SP_W = $clog2(DEPTH);
    localparam int HI_W = PC_W - 8;
    localparam logic [PC_W-1:0] MASK = PC_W'(MEM_WORDS - 1);

    logic any_br;
    assign any_br = op_irq | op_ret | op_call | op_goto | op_pcl_wr;

    always @(posedge clk) begin
        if (!rst_n) assert_reset_R1: assert (fetch_addr == '0 && sp_q == '0);
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_br && !op_inc) |=> $stable(fetch_addr));

    assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_br && op_inc) |=> fetch_addr == ((PC_W'($past(fetch_addr)) + PC_W'(1)) & MASK));

    assert_pcl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_pcl_wr && !op_irq && !op_ret && !op_call && !op_goto)
        |=> fetch_addr == ({$past(latch_q), $past(wr_data)} & MASK));

    assert_goto_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_goto || op_call) && !op_irq && !op_ret)
        |=> fetch_addr == ({$past(latch_q[HI_W-1 -: 2]), $past(imm)} & MASK));

    assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_irq |=> fetch_addr == PC_W'(4));

    assert_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_irq || (op_call && !op_ret)) |=> sp_q == SP_W'($past(sp_q) + SP_W'(1)));

    assert_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ret && !op_irq) |=> sp_q == SP_W'($past(sp_q) - SP_W'(1)));

    assert_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_latch_wr |=> $stable(latch_q));

    assert_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr & ~MASK) == '0);
endmodule

bind pcseq_top pcseq_chk #(
    .PC_W(PC_W), .IMM_W(IMM_W), .DEPTH(DEPTH), .MEM_WORDS(MEM_WORDS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_inc      (op_inc),
    .op_pcl_wr   (op_pcl_wr),
    .op_goto     (op_goto),
    .op_call     (op_call),
    .op_ret      (op_ret),
    .op_irq      (op_irq),
    .op_latch_wr (op_latch_wr),
    .wr_data     (wr_data),
    .imm         (imm),
    .fetch_addr  (fetch_addr),
    .latch_q     (latch_q),
    .sp_q        (sp_q)
);

// File: tb/sim_pcseq_top.sv
module sim_pcseq_top;
    localparam int MEMW = 4096;
    localparam logic [12:0] M = 13'(MEMW - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_inc = 0, op_pcl_wr = 0, op_goto = 0, op_call = 0;
    logic op_ret = 0, op_irq = 0, op_latch_wr = 0;
    logic [7:0]  wr_data = '0;
    logic [10:0] imm = '0;
    logic [12:0] fetch_addr;
    logic [7:0]  pcl_rd;

    int checks = 0;
    int errors = 0;

    logic [12:0] m_pc;
    logic [4:0]  m_lat;
    logic [12:0] m_stk [8];
    logic [2:0]  m_sp;

    always #2.5 clk = ~clk;

    pcseq_top #(.MEM_WORDS(MEMW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_inc(op_inc), .op_pcl_wr(op_pcl_wr),
        .op_goto(op_goto), .op_call(op_call), .op_ret(op_ret), .op_irq(op_irq),
        .op_latch_wr(op_latch_wr), .wr_data(wr_data), .imm(imm),
        .fetch_addr(fetch_addr), .pcl_rd(pcl_rd)
    );

    task automatic check(input string rq, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // s = {irq, ret, call, goto, pcl, inc, latch_wr}; called at a negedge
    task automatic step(input string rq, input logic [6:0] s,
                        input logic [7:0] d, input logic [10:0] im);
        logic [12:0] ra;
        logic [12:0] npc;
        {op_irq, op_ret, op_call, op_goto, op_pcl_wr, op_inc, op_latch_wr} = s;
        wr_data = d;
        imm = im;
        ra = (m_pc + 13'd1) & M;
        if (s[6]) begin
            m_stk[m_sp] = ra; m_sp = m_sp + 3'd1; npc = 13'd4;
        end else if (s[5]) begin
            m_sp = m_sp - 3'd1; npc = m_stk[m_sp];
        end else if (s[4]) begin
            m_stk[m_sp] = ra; m_sp = m_sp + 3'd1; npc = {m_lat[4:3], im} & M;
        end else if (s[3]) npc = {m_lat[4:3], im} & M;
        else if (s[2]) npc = {m_lat, d} & M;
        else if (s[1]) npc = ra;
        else npc = m_pc;
        if (s[0]) m_lat = d[4:0];
        m_pc = npc;
        @(posedge clk);
        @(negedge clk);
        {op_irq, op_ret, op_call, op_goto, op_pcl_wr, op_inc, op_latch_wr} = '0;
        check(rq, fetch_addr, m_pc);
        check({rq, " R3 pcl_rd"}, {5'd0, pcl_rd}, {5'd0, m_pc[7:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  dv [3];
        logic [10:0] iv [4];
        m_pc = '0; m_lat = '0; m_sp = '0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        dv[0] = 8'h00; dv[1] = 8'h5A; dv[2] = 8'hFF;
        iv[0] = 11'h000; iv[1] = 11'h7FF; iv[2] = 11'h2AA; iv[3] = 11'h400;

        repeat (3) @(negedge clk);
        check("R1 reset fetch", fetch_addr, 13'd0);
        check("R1 reset pcl", {5'd0, pcl_rd}, 13'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", fetch_addr, 13'd0);

        step("R10 hold", 7'b0000000, 8'h00, 11'h000);
        for (int i = 0; i < 5; i++) step("R2 inc", 7'b0000010, 8'h00, 11'h000);

        // R11: increment across top of memory
        step("R9 latch only", 7'b0000001, 8'h08, 11'h000);
        step("R4 goto", 7'b0001000, 8'h00, 11'h7FE);
        check("R4 goto to FFE", fetch_addr, 13'hFFE);
        step("R2 inc", 7'b0000010, 8'h00, 11'h000);
        step("R11 inc wrap", 7'b0000010, 8'h00, 11'h000);
        check("R11 wrap to zero", fetch_addr, 13'h000);

        // R3 sweep: all latch values against edge bytes
        for (int l = 0; l < 32; l++) begin
            step("R9 latch only", 7'b0000001, 8'(l), 11'h000);
            for (int k = 0; k < 3; k++) begin
                step("R3 pcl write", 7'b0000100, dv[k], 11'h000);
                check("R11 pcl bit4 dropped", fetch_addr, {1'b0, 4'(l), dv[k]});
            end
        end

        // R4 sweep: page bits against immediates
        for (int p = 0; p < 4; p++) begin
            step("R9 latch only", 7'b0000001, 8'(p << 3) | 8'h07, 11'h000);
            for (int k = 0; k < 4; k++) begin
                step("R4 goto", 7'b0001000, 8'hFF, iv[k]);
                check("R4 goto page", fetch_addr, {1'b0, 1'(p), iv[k]});
            end
            step("R9 latch persists", 7'b0000100, 8'h33, 11'h000);
            check("R9 latch persists", fetch_addr, {1'b0, 1'(p), 3'b111, 8'h33});
        end

        // R5/R6/R7 call, interrupt, return
        step("R9 latch only", 7'b0000001, 8'h00, 11'h000);
        step("R4 goto", 7'b0001000, 8'h00, 11'h050);
        step("R5 call", 7'b0010000, 8'h00, 11'h300);
        step("R7 irq", 7'b1000000, 8'h00, 11'h000);
        check("R7 vector", fetch_addr, 13'd4);
        step("R6 ret", 7'b0100000, 8'h00, 11'h000);
        check("R6 ret from irq", fetch_addr, 13'h301);
        step("R6 ret", 7'b0100000, 8'h00, 11'h000);
        check("R6 ret from call", fetch_addr, 13'h051);

        // R8 ring: ten calls then ten returns
        for (int k = 0; k < 10; k++) begin
            step("R4 goto", 7'b0001000, 8'h00, 11'(16'h100 + k * 16));
            step("R5 call", 7'b0010000, 8'h00, 11'h200);
        end
        for (int j = 0; j < 10; j++) begin
            int kk;
            kk = (j < 8) ? (9 - j) : (17 - j);
            step("R8 ret", 7'b0100000, 8'h00, 11'h000);
            check("R8 ring order", fetch_addr, 13'(16'h101 + kk * 16));
        end

        // R12 priorities
        step("R12 irq over inc", 7'b1000010, 8'h00, 11'h000);
        check("R12 irq wins", fetch_addr, 13'd4);
        step("R12 ret over call", 7'b0110000, 8'h00, 11'h123);
        step("R12 call over goto", 7'b0011000, 8'h00, 11'h456);
        step("R12 goto over pcl", 7'b0001100, 8'h77, 11'h0AB);
        check("R12 goto wins", fetch_addr, 13'h0AB);
        step("R12 pcl over inc", 7'b0000110, 8'h99, 11'h000);
        step("R12 pcl with latch write", 7'b0000101, 8'h1F, 11'h000);
        step("R3 uses new latch", 7'b0000100, 8'h10, 11'h000);
        check("R3 new latch", fetch_addr, 13'hF10);
        step("R10 hold", 7'b0000000, 8'hAA, 11'h7FF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule